// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a small fully associative cache of address translations. A requester presents a virtual page number along with the identifier of the running address space. Every stored entry compares both values at the same time. One cycle later the block reports whether the lookup hit and, on a hit, the physical frame number. On a miss the requester fetches the translation elsewhere and writes it back through the fill port, so the next reference to that page hits.

Each entry carries a pinned flag. A pinned entry is never picked as a victim and survives both flush commands. A fill goes first to the lowest-numbered empty slot. When no slot is empty, the fill replaces the least recently used entry that is not pinned. A fill whose page number and identifier are already stored rewrites that entry, so no duplicate is created. If every entry is pinned, the fill is dropped and a reject pulse is raised. There are two flush commands: one clears every unpinned entry, and the other clears only the unpinned entries that belong to one address space.

Top module: `tlb_asid_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high gives `lk_done` high on the next cycle. On that cycle `lk_hit` is high and `lk_pfn` carries the stored frame only when a valid entry holds both the presented page number and the presented identifier. On a miss `lk_pfn` is zero.
- R2: An entry whose page number matches but whose stored identifier differs from `lk_asid` yields a miss.
- R3: An accepted fill is visible to lookups presented from the next cycle on. A lookup in the same cycle as the fill sees the contents from before the fill.
- R4: A fill with no matching entry takes the lowest-indexed invalid slot before any valid entry is replaced.
- R5: When all slots are valid, a fill replaces the unpinned entry that was used least recently. An entry counts as used when a fill is accepted into it. In a cycle with no accepted fill, an entry also counts as used when a lookup hits it.
- R6: A pinned entry (filled with `fill_wired` high) is never replaced by a fill to a different page.
- R7: When every entry is pinned, a fill with no match leaves the contents unchanged, and `fill_reject` pulses high on the next cycle.
- R8: A fill whose page number and identifier match a valid entry rewrites that entry's frame and pinned flag in place. No second copy is created.
- R9: `flush_all` invalidates every unpinned entry and leaves pinned entries valid.
- R10: `flush_asid_valid` invalidates only the unpinned entries whose identifier equals `flush_asid_id`.
- R11: The commands have a fixed priority: `flush_all` first, then `flush_asid_valid`, then `fill_valid`. A fill that arrives together with a flush is ignored and raises no reject.
- R12: While `rst` is high, all entries become invalid and `lk_done`, `lk_hit`, `lk_pfn` and `fill_reject` are zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_done | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup found a translation |
| lk_pfn | output | PFN_W | Frame number on hit, zero on miss |
| fill_valid | input | 1 | Insert a translation |
| fill_vpn | input | VPN_W | Page number to insert |
| fill_pfn | input | PFN_W | Frame number to insert |
| fill_asid | input | ASID_W | Identifier to insert |
| fill_wired | input | 1 | Pin the inserted entry |
| fill_reject | output | 1 | Previous fill dropped because all entries are pinned |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid_valid | input | 1 | Invalidate unpinned entries of one identifier |
| flush_asid_id | input | ASID_W | Identifier for the selective flush |

## Verification
The bench builds the block with 4 entries, 8-bit page numbers, 6-bit frames and 3-bit identifiers. With only four slots, a few fills are enough to fill the cache, so the bench can drive least-recently-used eviction, eviction skipping a pinned entry, and the all-pinned reject case in short directed sequences. A random phase afterwards uses eight page numbers and four identifiers. This small key space makes duplicate fills, identifier mismatches and fills colliding with flushes or lookups common.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_FILL,
    CMD_FLUSH_ASID,
    CMD_FLUSH_ALL
  } tlb_cmd_e;
endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8
) (
  input  logic [N_ENTRIES-1:0] valid_vec,
  input  logic [VPN_W-1:0]     ent_vpn  [N_ENTRIES],
  input  logic [ASID_W-1:0]    ent_asid [N_ENTRIES],
  input  logic [VPN_W-1:0]     key_vpn,
  input  logic [ASID_W-1:0]    key_asid,
  output logic [N_ENTRIES-1:0] match_vec
);
  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] &&
                          (ent_vpn[g] == key_vpn) &&
                          (ent_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch_en,
  input  logic [IDX_W-1:0]     touch_idx,
  input  logic [N_ENTRIES-1:0] valid_vec,
  input  logic [N_ENTRIES-1:0] wired_vec,
  output logic [IDX_W-1:0]     victim_idx,
  output logic                 victim_ok
);
  // age 0 = most recent; ages form a permutation of 0..N-1
  logic [IDX_W-1:0] age [N_ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (i == int'(touch_idx))    age[i] <= '0;
        else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
      end
    end
  end

  logic             free_found, old_found;
  logic [IDX_W-1:0] free_idx, old_idx, old_age;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    old_found = 1'b0;
    old_idx   = '0;
    old_age   = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (valid_vec[i] && !wired_vec[i] && (!old_found || age[i] > old_age)) begin
        old_found = 1'b1;
        old_idx   = IDX_W'(i);
        old_age   = age[i];
      end
    end
    victim_ok  = free_found || old_found;
    victim_idx = free_found ? free_idx : old_idx;
  end
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 16,
  parameter int ASID_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_wired,
  output logic              fill_reject,
  input  logic              flush_all,
  input  logic              flush_asid_valid,
  input  logic [ASID_W-1:0] flush_asid_id
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  // entry storage: payload arrays without reset, status bits with reset
  logic [VPN_W-1:0]     ent_vpn  [N_ENTRIES];
  logic [PFN_W-1:0]     ent_pfn  [N_ENTRIES];
  logic [ASID_W-1:0]    ent_asid [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_vec, wired_vec;

  logic [N_ENTRIES-1:0] lk_match, fill_match;

  tlb_match_array #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
    .valid_vec(valid_vec), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match_vec(lk_match)
  );

  tlb_match_array #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
    .valid_vec(valid_vec), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match_vec(fill_match)
  );

  // one-hot reductions: frame value and entry index
  logic [PFN_W-1:0] lk_pfn_or;
  logic [IDX_W-1:0] lk_idx, dup_idx;

  always_comb begin
    lk_pfn_or = '0;
    lk_idx    = '0;
    dup_idx   = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      lk_pfn_or = lk_pfn_or | ({PFN_W{lk_match[i]}} & ent_pfn[i]);
      lk_idx    = lk_idx    | ({IDX_W{lk_match[i]}} & IDX_W'(i));
      dup_idx   = dup_idx   | ({IDX_W{fill_match[i]}} & IDX_W'(i));
    end
  end

  // command decode with fixed priority
  tlb_cmd_e cmd;
  always_comb begin
    if (flush_all)             cmd = CMD_FLUSH_ALL;
    else if (flush_asid_valid) cmd = CMD_FLUSH_ASID;
    else if (fill_valid)       cmd = CMD_FILL;
    else                       cmd = CMD_IDLE;
  end

  logic             victim_ok, fill_dup, fill_accept, fill_drop, lk_any;
  logic [IDX_W-1:0] victim_idx, fill_idx, touch_idx;

  assign fill_dup    = |fill_match;
  assign fill_idx    = fill_dup ? dup_idx : victim_idx;
  assign fill_accept = (cmd == CMD_FILL) && (fill_dup || victim_ok);
  assign fill_drop   = (cmd == CMD_FILL) && !fill_accept;
  assign lk_any      = lk_valid && (|lk_match);
  assign touch_idx   = fill_accept ? fill_idx : lk_idx;

  tlb_victim_sel #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk(clk), .rst(rst),
    .touch_en(fill_accept || lk_any), .touch_idx(touch_idx),
    .valid_vec(valid_vec), .wired_vec(wired_vec),
    .victim_idx(victim_idx), .victim_ok(victim_ok)
  );

  // payload write port
  always_ff @(posedge clk) begin
    if (fill_accept) begin
      ent_vpn[fill_idx]  <= fill_vpn;
      ent_pfn[fill_idx]  <= fill_pfn;
      ent_asid[fill_idx] <= fill_asid;
    end
  end

  // status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
      wired_vec <= '0;
    end else begin
      unique case (cmd)
        CMD_FLUSH_ALL: valid_vec <= valid_vec & wired_vec;
        CMD_FLUSH_ASID: begin
          for (int i = 0; i < N_ENTRIES; i++)
            if (!wired_vec[i] && ent_asid[i] == flush_asid_id) valid_vec[i] <= 1'b0;
        end
        CMD_FILL: begin
          if (fill_accept) begin
            valid_vec[fill_idx] <= 1'b1;
            wired_vec[fill_idx] <= fill_wired;
          end
        end
        default: ;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done     <= 1'b0;
      lk_hit      <= 1'b0;
      lk_pfn      <= '0;
      fill_reject <= 1'b0;
    end else begin
      lk_done     <= lk_valid;
      lk_hit      <= lk_any;
      lk_pfn      <= lk_valid ? lk_pfn_or : '0;
      fill_reject <= fill_drop;
    end
  end
endmodule

// File: rtl/tlb_asid_sva.sv
module tlb_asid_sva #(
  parameter int N_ENTRIES = 16,
  parameter int PFN_W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lk_valid,
  input logic                 lk_done,
  input logic                 lk_hit,
  input logic [PFN_W-1:0]     lk_pfn,
  input logic                 fill_valid,
  input logic                 flush_all,
  input logic                 flush_asid_valid,
  input logic                 fill_reject,
  input logic [N_ENTRIES-1:0] lk_match,
  input logic [N_ENTRIES-1:0] valid_vec,
  input logic [N_ENTRIES-1:0] wired_vec
);
  a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done);

  a_r1_miss_zero_pfn: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> (lk_pfn == '0));

  a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  a_r6_wired_kept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(wired_vec) & ~valid_vec) == '0));

  a_r7_reject_cause: assert property (@(posedge clk) disable iff (rst)
    fill_reject |-> $past(fill_valid && !flush_all && !flush_asid_valid && (&wired_vec)));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> ((valid_vec & ~$past(wired_vec)) == '0));

  a_r11_no_reject_on_flush: assert property (@(posedge clk) disable iff (rst)
    (flush_all || flush_asid_valid) |=> !fill_reject);
endmodule

bind tlb_asid_cache tlb_asid_sva #(.N_ENTRIES(N_ENTRIES), .PFN_W(PFN_W)) u_sva (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_done(lk_done), .lk_hit(lk_hit),
  .lk_pfn(lk_pfn), .fill_valid(fill_valid), .flush_all(flush_all),
  .flush_asid_valid(flush_asid_valid), .fill_reject(fill_reject),
  .lk_match(lk_match), .valid_vec(valid_vec), .wired_vec(wired_vec)
);

// File: tb/tb_tlb_asid_cache.sv
module tb_tlb_asid_cache;
  localparam int N = 4, VW = 8, PW = 6, AW = 3;

  logic clk = 1'b0, rst;
  logic lk_valid, lk_done, lk_hit, fill_valid, fill_wired, fill_reject;
  logic flush_all, flush_asid_valid;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [AW-1:0] lk_asid, fill_asid, flush_asid_id;
  logic [PW-1:0] lk_pfn, fill_pfn;

  always #5 clk = ~clk;

  tlb_asid_cache #(.N_ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_asid(fill_asid), .fill_wired(fill_wired), .fill_reject(fill_reject),
    .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid_id(flush_asid_id)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          mv [N], mw [N];
  int          mvpn [N], masid [N], mpfn [N], mstamp [N];
  int          tnow = 0;
  bit          exp_done, exp_hit, exp_rej;
  int          exp_pfn;

  always @(posedge clk) begin : model
    int hit_i, tgt, best;
    if (rst) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mw[i] = 0; end
      exp_done = 0; exp_hit = 0; exp_pfn = 0; exp_rej = 0;
    end else begin
      hit_i = -1;
      for (int i = 0; i < N; i++)
        if (mv[i] && mvpn[i] == int'(lk_vpn) && masid[i] == int'(lk_asid)) hit_i = i;
      exp_done = lk_valid;
      exp_hit  = lk_valid && hit_i >= 0;
      exp_pfn  = exp_hit ? mpfn[hit_i] : 0;
      exp_rej  = 0;
      tgt = -1;
      if (flush_all) begin
        for (int i = 0; i < N; i++) if (!mw[i]) mv[i] = 0;
      end else if (flush_asid_valid) begin
        for (int i = 0; i < N; i++) if (!mw[i] && masid[i] == int'(flush_asid_id)) mv[i] = 0;
      end else if (fill_valid) begin
        for (int i = 0; i < N; i++)
          if (mv[i] && mvpn[i] == int'(fill_vpn) && masid[i] == int'(fill_asid)) tgt = i;
        if (tgt < 0)
          for (int i = N - 1; i >= 0; i--) if (!mv[i]) tgt = i;
        if (tgt < 0) begin
          best = -1;
          for (int i = 0; i < N; i++)
            if (mv[i] && !mw[i] && (best < 0 || mstamp[i] < mstamp[best])) best = i;
          tgt = best;
        end
        if (tgt < 0) exp_rej = 1;
        else begin
          mv[tgt] = 1; mw[tgt] = fill_wired; mvpn[tgt] = int'(fill_vpn);
          masid[tgt] = int'(fill_asid); mpfn[tgt] = int'(fill_pfn);
          tnow++; mstamp[tgt] = tnow;
        end
      end
      if (tgt < 0 && exp_hit) begin tnow++; mstamp[hit_i] = tnow; end
    end
  end

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = 0; lk_asid = 0;
    fill_valid = 0; fill_vpn = 0; fill_pfn = 0; fill_asid = 0; fill_wired = 0;
    flush_all = 0; flush_asid_valid = 0; flush_asid_id = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    chk(cur_req, "lk_done", lk_done, exp_done);
    chk(cur_req, "lk_hit", lk_hit, exp_hit);
    chk(cur_req, "lk_pfn", lk_pfn, exp_pfn);
    chk(cur_req, "fill_reject", fill_reject, exp_rej);
    idle_inputs();
  endtask

  task automatic do_fill(int vpn, int asid, int pfn, bit w);
    fill_valid = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid);
    fill_pfn = PW'(pfn); fill_wired = w;
    tick();
  endtask

  task automatic look(int vpn, int asid, bit eh, int ep, string req);
    cur_req = req;
    lk_valid = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid);
    tick();
    chk(req, "hit", lk_hit, eh);
    chk(req, "pfn", lk_pfn, ep);
  endtask

  task automatic flush_id(int id);
    flush_asid_valid = 1; flush_asid_id = AW'(id);
    tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    cur_req = "R12";
    chk("R12", "lk_done", lk_done, 0);
    chk("R12", "lk_hit", lk_hit, 0);
    chk("R12", "lk_pfn", lk_pfn, 0);
    chk("R12", "fill_reject", fill_reject, 0);
    rst = 0;
    tick();

    look(8'h10, 1, 0, 0, "R1");
    cur_req = "R3";
    do_fill(8'h10, 1, 5, 0); do_fill(8'h11, 1, 6, 0);
    do_fill(8'h12, 2, 7, 0); do_fill(8'h13, 2, 8, 0);
    look(8'h10, 1, 1, 5, "R3");
    look(8'h10, 2, 0, 0, "R2");
    look(8'h12, 2, 1, 7, "R1");
    cur_req = "R5";
    do_fill(8'h20, 1, 9, 0);
    look(8'h11, 1, 0, 0, "R5");
    look(8'h20, 1, 1, 9, "R5");
    cur_req = "R8";
    do_fill(8'h10, 1, 3, 1);
    look(8'h10, 1, 1, 3, "R8");
    cur_req = "R6";
    do_fill(8'h30, 3, 10, 0); do_fill(8'h31, 3, 11, 0);
    do_fill(8'h32, 3, 12, 0); do_fill(8'h33, 3, 13, 0);
    look(8'h10, 1, 1, 3, "R6");
    look(8'h30, 3, 0, 0, "R6");
    cur_req = "R10";
    flush_id(3);
    look(8'h31, 3, 0, 0, "R10");
    look(8'h10, 1, 1, 3, "R10");
    do_fill(8'h40, 1, 14, 0); do_fill(8'h41, 3, 15, 0);
    flush_id(3);
    look(8'h40, 1, 1, 14, "R10");
    look(8'h41, 3, 0, 0, "R10");
    cur_req = "R4";
    do_fill(8'h50, 1, 16, 0); do_fill(8'h51, 1, 17, 0);
    look(8'h40, 1, 1, 14, "R4");
    look(8'h50, 1, 1, 16, "R4");
    cur_req = "R7";
    do_fill(8'h40, 1, 14, 1); do_fill(8'h50, 1, 16, 1); do_fill(8'h51, 1, 17, 1);
    do_fill(8'h60, 2, 20, 0);
    chk("R7", "fill_reject", fill_reject, 1);
    look(8'h60, 2, 0, 0, "R7");
    look(8'h51, 1, 1, 17, "R7");
    cur_req = "R11";
    do_fill(8'h51, 1, 17, 0);
    flush_all = 1;
    do_fill(8'h70, 1, 21, 0);
    chk("R11", "fill_reject", fill_reject, 0);
    look(8'h51, 1, 0, 0, "R9");
    look(8'h50, 1, 1, 16, "R9");
    look(8'h70, 1, 0, 0, "R11");
    flush_asid_valid = 1; flush_asid_id = 2;
    do_fill(8'h71, 2, 22, 0);
    look(8'h71, 2, 0, 0, "R11");

    cur_req = "R5";
    for (int k = 0; k < 600; k++) begin
      int op;
      lk_valid = ($urandom_range(0, 3) != 0);
      lk_vpn   = VW'($urandom_range(0, 7));
      lk_asid  = AW'($urandom_range(0, 3));
      op = $urandom_range(0, 19);
      if (op < 9) begin
        fill_valid = 1; fill_vpn = VW'($urandom_range(0, 7));
        fill_asid = AW'($urandom_range(0, 3)); fill_pfn = PW'($urandom_range(0, 63));
        fill_wired = ($urandom_range(0, 7) == 0);
      end
      if (op == 9)  flush_all = 1;
      if (op == 10) begin flush_asid_valid = 1; flush_asid_id = AW'($urandom_range(0, 3)); end
      tick();
    end
    finish_run();
  end
endmodule